// File: doc/BRIEF.md
# Audio Secondary Packet Scheduler

This block decides when the audio side of a display transmitter asks a downstream secondary-stream encoder for packets. Its only time base is a one-cycle pulse that marks each blanking-start symbol. Every pulse asks for one audio sample packet. Every 512th pulse also asks for an audio timestamp packet and then an audio InfoFrame packet. The block has no video-state input, so it keeps the audio stream alive in exactly the same way when no video is being sent.

Requests leave the block one at a time through a request/acknowledge pair, and each carries a packet-type code. The block also drives the fixed audio M value that goes into the timestamp packet. It holds a shadow copy of the InfoFrame configuration fields: channel-count code, LFE playback level, channel allocation, level shift and downmix inhibit. That copy is refreshed only on the 512-pulse boundary, so a single InfoFrame never mixes old and new settings. When a sample request has not been delivered by the time the next pulse arrives, the block drops the extra request and raises a sticky overflow flag.

Top module: `audio_pkt_sched`

## Requirements
- R1: After reset, `pktReq` is 0, `overflow` is 0 and every shadow field output (`ifChanCode`, `ifLfeLevel`, `ifChanAlloc`, `ifLevelShift`, `ifDownmixInh`, `ifLayoutMulti`) is 0.
- R2: Each `bsPulse` produces exactly one delivered sample request (`pktType` = 2'd0), except for the duplicate case in R3.
- R3: If a `bsPulse` arrives while an earlier sample request is still undelivered, that pulse adds no request and `overflow` becomes 1. `overflow` then stays 1 until reset.
- R4: The pulse that takes an internal 9-bit pulse counter from 511 back to 0, which is every 512th pulse counted from reset, also requests a timestamp (`pktType` = 2'd1) and then an InfoFrame (`pktType` = 2'd2). The order is sample, then timestamp, then InfoFrame.
- R5: At most one request is outstanding. While `pktReq` is 1 and `pktAck` is 0, both `pktReq` and `pktType` hold their values. A handshake completes on a clock edge where `pktReq` and `pktAck` are both 1.
- R6: `mAud` always equals 24'h008000.
- R7: The shadow field outputs take the values of the configuration inputs only on the wrapping pulse of R4. At all other times they hold their values, whatever the inputs do.
- R8: `ifLayoutMulti` is 0 when the captured channel-count code is 3'b000, which is the two-channel layout used for one or two channels. For any other code it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bsPulse | input | 1 | One-cycle pulse per blanking-start symbol |
| pktAck | input | 1 | Downstream encoder accepts the current request |
| chanCode | input | 3 | Channel-count configuration code |
| lfeLevel | input | 2 | LFE playback level field |
| chanAlloc | input | 8 | Speaker/channel allocation field |
| levelShift | input | 4 | Level shift field |
| downmixInh | input | 1 | Downmix inhibit field |
| pktReq | output | 1 | A packet request is outstanding |
| pktType | output | 2 | 0 sample, 1 timestamp, 2 InfoFrame |
| overflow | output | 1 | Sticky flag: a sample request was dropped |
| mAud | output | 24 | Fixed audio M value for the timestamp |
| ifChanCode | output | 3 | Captured channel-count code |
| ifLfeLevel | output | 2 | Captured LFE playback level |
| ifChanAlloc | output | 8 | Captured channel allocation |
| ifLevelShift | output | 4 | Captured level shift |
| ifDownmixInh | output | 1 | Captured downmix inhibit |
| ifLayoutMulti | output | 1 | 0 for two-channel layout, 1 otherwise |

## Verification
The bench steps across two full 512-pulse periods, and the scoreboard checks the order of packets at each boundary. A counter that is off by one would put the timestamp and InfoFrame pair on pulse 511 or 513. A wrong arbitration priority would put the InfoFrame ahead of the timestamp, or the sample behind them. The configuration inputs change in the middle of a period: a design that captured them continuously would show the new fields before the boundary. Stalling the acknowledge across two pulses checks three things: the request must stay frozen, a second sample must not be queued, and `overflow` must set and stay set.

// File: rtl/aps_pkg.sv
package aps_pkg;
  typedef enum logic [1:0] {
    PKT_SAMPLE = 2'd0,
    PKT_STAMP  = 2'd1,
    PKT_INFO   = 2'd2
  } pkt_e;

  typedef struct packed {
    logic capture;  // refresh the InfoFrame shadow fields
  } strobe_t;
endpackage

// File: rtl/aps_ctrl.sv
module aps_ctrl
  import aps_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bsPulse,
  input  logic    pktAck,
  output logic    pktReq,
  output pkt_e    pktType,
  output logic    overflow,
  output strobe_t strb
);
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] bsCnt;
  logic sampPend, stampPend, infoPend;
  logic reqValid;
  pkt_e reqType;
  logic wrap, sampBusy, dup, canLoad;
  logic loadSamp, loadStamp, loadInfo;

  assign wrap     = bsPulse && (bsCnt == CNT_LAST);
  assign sampBusy = sampPend || (reqValid && reqType == PKT_SAMPLE && !pktAck);
  assign dup      = bsPulse && sampBusy;
  assign canLoad  = !reqValid;

  // fixed priority: sample, then timestamp, then InfoFrame
  always_comb begin
    loadSamp  = 1'b0;
    loadStamp = 1'b0;
    loadInfo  = 1'b0;
    if (canLoad) begin
      if (sampPend)       loadSamp  = 1'b1;
      else if (stampPend) loadStamp = 1'b1;
      else if (infoPend)  loadInfo  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bsCnt     <= '0;
      sampPend  <= 1'b0;
      stampPend <= 1'b0;
      infoPend  <= 1'b0;
      reqValid  <= 1'b0;
      reqType   <= PKT_SAMPLE;
      overflow  <= 1'b0;
    end else begin
      if (bsPulse) bsCnt <= bsCnt + 1'b1;

      if (bsPulse && !sampBusy) sampPend <= 1'b1;
      else if (loadSamp)        sampPend <= 1'b0;

      if (wrap)           stampPend <= 1'b1;
      else if (loadStamp) stampPend <= 1'b0;

      if (wrap)          infoPend <= 1'b1;
      else if (loadInfo) infoPend <= 1'b0;

      if (dup) overflow <= 1'b1;

      if (reqValid && pktAck) begin
        reqValid <= 1'b0;
      end else if (loadSamp || loadStamp || loadInfo) begin
        reqValid <= 1'b1;
        reqType  <= loadSamp ? PKT_SAMPLE : (loadStamp ? PKT_STAMP : PKT_INFO);
      end
    end
  end

  assign pktReq  = reqValid;
  assign pktType = reqType;
  assign strb.capture = wrap;

  p_hold_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pktReq && !pktAck) |=> (pktReq && $stable(pktType)));
  p_drop_after_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pktReq && pktAck) |=> !pktReq);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  p_stamp_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pktReq && pktType == PKT_INFO) |-> !stampPend);
endmodule

// File: rtl/aps_dpath.sv
module aps_dpath
  import aps_pkg::*;
#(
  parameter int          MAUD_W   = 24,
  parameter logic [23:0] MAUD_VAL = 24'h008000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [2:0]        chanCode,
  input  logic [1:0]        lfeLevel,
  input  logic [7:0]        chanAlloc,
  input  logic [3:0]        levelShift,
  input  logic              downmixInh,
  output logic [MAUD_W-1:0] mAud,
  output logic [2:0]        ifChanCode,
  output logic [1:0]        ifLfeLevel,
  output logic [7:0]        ifChanAlloc,
  output logic [3:0]        ifLevelShift,
  output logic              ifDownmixInh,
  output logic              ifLayoutMulti
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ifChanCode   <= '0;
      ifLfeLevel   <= '0;
      ifChanAlloc  <= '0;
      ifLevelShift <= '0;
      ifDownmixInh <= 1'b0;
    end else if (strb.capture) begin
      ifChanCode   <= chanCode;
      ifLfeLevel   <= lfeLevel;
      ifChanAlloc  <= chanAlloc;
      ifLevelShift <= levelShift;
      ifDownmixInh <= downmixInh;
    end
  end

  assign ifLayoutMulti = (ifChanCode != 3'b000);
  assign mAud = MAUD_VAL[MAUD_W-1:0];

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(ifChanAlloc) && $stable(ifChanCode)
                       && $stable(ifLevelShift) && $stable(ifLfeLevel)
                       && $stable(ifDownmixInh)));
endmodule

// File: rtl/audio_pkt_sched.sv
module audio_pkt_sched
  import aps_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int MAUD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bsPulse,
  input  logic              pktAck,
  input  logic [2:0]        chanCode,
  input  logic [1:0]        lfeLevel,
  input  logic [7:0]        chanAlloc,
  input  logic [3:0]        levelShift,
  input  logic              downmixInh,
  output logic              pktReq,
  output logic [1:0]        pktType,
  output logic              overflow,
  output logic [MAUD_W-1:0] mAud,
  output logic [2:0]        ifChanCode,
  output logic [1:0]        ifLfeLevel,
  output logic [7:0]        ifChanAlloc,
  output logic [3:0]        ifLevelShift,
  output logic              ifDownmixInh,
  output logic              ifLayoutMulti
);
  strobe_t strb;
  pkt_e    typeInt;

  aps_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bsPulse(bsPulse), .pktAck(pktAck),
    .pktReq(pktReq), .pktType(typeInt), .overflow(overflow), .strb(strb)
  );

  aps_dpath #(.MAUD_W(MAUD_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .chanCode(chanCode), .lfeLevel(lfeLevel), .chanAlloc(chanAlloc),
    .levelShift(levelShift), .downmixInh(downmixInh),
    .mAud(mAud), .ifChanCode(ifChanCode), .ifLfeLevel(ifLfeLevel),
    .ifChanAlloc(ifChanAlloc), .ifLevelShift(ifLevelShift),
    .ifDownmixInh(ifDownmixInh), .ifLayoutMulti(ifLayoutMulti)
  );

  assign pktType = typeInt;
endmodule

// File: tb/sim_audio_pkt_sched.sv
module sim_audio_pkt_sched;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bsPulse = 1'b0;
  logic ackEn = 1'b1;
  logic pktAck;
  logic [2:0] chanCode = '0;
  logic [1:0] lfeLevel = '0;
  logic [7:0] chanAlloc = '0;
  logic [3:0] levelShift = '0;
  logic downmixInh = 1'b0;
  logic pktReq, overflow, ifDownmixInh, ifLayoutMulti;
  logic [1:0] pktType, ifLfeLevel;
  logic [23:0] mAud;
  logic [2:0] ifChanCode;
  logic [7:0] ifChanAlloc;
  logic [3:0] ifLevelShift;

  int nChecks = 0;
  int nFails = 0;
  int bsCount = 0;
  int cycles = 0;
  logic [1:0] expQ[$];

  always #5 clk = ~clk;
  assign pktAck = ackEn & pktReq;

  audio_pkt_sched u0 (
    .clk(clk), .rstN(rstN), .bsPulse(bsPulse), .pktAck(pktAck),
    .chanCode(chanCode), .lfeLevel(lfeLevel), .chanAlloc(chanAlloc),
    .levelShift(levelShift), .downmixInh(downmixInh),
    .pktReq(pktReq), .pktType(pktType), .overflow(overflow), .mAud(mAud),
    .ifChanCode(ifChanCode), .ifLfeLevel(ifLfeLevel), .ifChanAlloc(ifChanAlloc),
    .ifLevelShift(ifLevelShift), .ifDownmixInh(ifDownmixInh),
    .ifLayoutMulti(ifLayoutMulti)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // monitor: a handshake completes at the next posedge
  always @(negedge clk) begin
    #1;
    if (rstN && pktReq && ackEn) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected request", {30'd0, pktType}, 32'hFF);
      end else begin
        check("R4 packet order", {30'd0, pktType}, {30'd0, expQ.pop_front()});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finishRun();
    end
  end

  // driver: one pulse; dup marks a pulse expected to be dropped (R3)
  task automatic sendBs(input bit dup, input int gap);
    @(negedge clk);
    bsPulse = 1'b1;
    bsCount++;
    if (!dup) expQ.push_back(2'd0);
    if (bsCount % 512 == 0) begin
      expQ.push_back(2'd1);
      expQ.push_back(2'd2);
    end
    @(negedge clk);
    bsPulse = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pktReq", pktReq, 0);
    check("R1 overflow", overflow, 0);
    check("R1 ifChanAlloc", ifChanAlloc, 0);
    check("R1 ifLayoutMulti", ifLayoutMulti, 0);
    check("R6 mAud", mAud, 32'h8000);

    chanCode = 3'b000; lfeLevel = 2'd2; chanAlloc = 8'h13;
    levelShift = 4'd5; downmixInh = 1'b1;
    for (int i = 0; i < 511; i++) sendBs(0, 4);
    check("R7 no early capture", ifChanAlloc, 0);
    check("R7 no early capture shift", ifLevelShift, 0);
    sendBs(0, 10);
    check("R7 capture alloc", ifChanAlloc, 32'h13);
    check("R7 capture lfe", ifLfeLevel, 2);
    check("R7 capture shift", ifLevelShift, 5);
    check("R7 capture inhibit", ifDownmixInh, 1);
    check("R8 two-channel layout", ifLayoutMulti, 0);
    check("R4 queue drained", expQ.size(), 0);

    chanCode = 3'b010; lfeLevel = 2'd1; chanAlloc = 8'h0B;
    levelShift = 4'd9; downmixInh = 1'b0;
    for (int i = 0; i < 100; i++) sendBs(0, 4);
    check("R7 hold mid period", ifChanAlloc, 32'h13);
    check("R8 hold layout", ifLayoutMulti, 0);

    // stall the acknowledge across two pulses
    ackEn = 1'b0;
    sendBs(0, 3);
    check("R5 request held", pktReq, 1);
    check("R5 type sample", pktType, 0);
    check("R3 no overflow yet", overflow, 0);
    sendBs(1, 3);
    check("R3 overflow set", overflow, 1);
    check("R5 request still held", pktReq, 1);
    check("R5 type stable", pktType, 0);
    ackEn = 1'b1;
    repeat (10) @(negedge clk);
    check("R3 duplicate dropped", expQ.size(), 0);
    check("R3 no extra request", pktReq, 0);

    for (int i = 0; i < 410; i++) sendBs(0, 4);
    repeat (10) @(negedge clk);
    check("R7 second capture alloc", ifChanAlloc, 32'h0B);
    check("R7 second capture shift", ifLevelShift, 9);
    check("R8 multi layout", ifLayoutMulti, 1);
    check("R3 overflow sticky", overflow, 1);
    check("R2 all samples delivered", expQ.size(), 0);
    check("R6 mAud constant", mAud, 32'h8000);
    finishRun();
  end
endmodule